// File: doc/BRIEF.md
# Dual-Path Bus Transceiver With Selectable Storage Mode

This block moves 18-bit words between two buses, A and B, with one independent path per direction. Each path holds one storage register that can act in three ways, picked by that path's controls. With the path's hold-release input high, the output follows the source bus combinationally. With it low, the path either keeps its stored word or loads the source on a rising transition of the path's strobe input. Each path also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low.

Every control and data input is sampled on the block's system clock. A strobe rising edge is a strobe seen low on one system-clock sample and high on the next. Each bus side is shown as a data vector plus a drive-enable bit in place of a tri-state pad. When a side is not driven, its data vector reads all zeros. The stored word is kept while that side is not driven. Both paths come from one path module that is built twice, with the enable polarity set by a parameter.

Top module: `duplex_bus_xcvr`

## Requirements
- R1: While `ab_le` is 1 and `ab_oe` is 1, `b_out` equals `a_in` in the same cycle, combinationally, with no clock edge needed.
- R2: While `ab_le` is 0 and no `ab_clk` rising edge is sampled, `b_out` keeps the stored word, and changes on `a_in` have no effect on it.
- R3: While `ab_le` is 0, a sampled rising edge of `ab_clk` (0 on one system-clock sample, 1 on the next) stores the `a_in` value from the sample where 1 was seen. The new word appears on `b_out` after that system-clock edge.
- R4: `ab_oe` is active high. When it is 0, `b_drv` is 0 and `b_out` reads all zeros.
- R5: The B-to-A path behaves like the A-to-B path: `ba_le`, `ba_clk`, `b_in` and `a_out` take the roles of R1 to R3. Its enable `ba_oe_n` is active low: 1 gives `a_drv` = 0 and `a_out` all zeros.
- R6: If the hold-release input falls while the path strobe is high, the word present at that moment is kept while the strobe later falls and stays low. Only the next rising strobe edge loads a new word.
- R7: The stored word is kept while the output is disabled. When the output is enabled again, it shows the last stored word, including one loaded while disabled.
- R8: `rst_n` low clears both stored words to zero at once, without waiting for a clock. Release takes effect after two system-clock edges.
- R9: The two paths are independent. Activity on one path's inputs does not change the other path's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| a_in | input | 18 | Data read from bus A |
| b_in | input | 18 | Data read from bus B |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B hold release: 1 = transparent |
| ab_clk | input | 1 | A-to-B load strobe, rising edge loads |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A hold release: 1 = transparent |
| ba_clk | input | 1 | B-to-A load strobe, rising edge loads |
| b_out | output | 18 | Data driven onto bus B |
| b_drv | output | 1 | Bus B drive enable |
| a_out | output | 18 | Data driven onto bus A |
| a_drv | output | 1 | Bus A drive enable |

## Verification
The hardest case is the hold-release input falling while the strobe is high (R6). The strobe must already be high before hold-release drops, so a later strobe fall and low period must not disturb the word. The stimulus raises the strobe while the path is still transparent, lowers hold-release a cycle later and then changes the source. It steps the strobe low and then high again, and checks that only the final rise loads. A second hard case is a load made while the output is disabled (R7). It is visible only after the enable is restored.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int XCVR_W = 18;
  localparam int NUM_PATHS = 2;
  localparam int RST_STAGES = 2;

  typedef struct packed {
    logic le;   // hold release: 1 = transparent
    logic stb;  // load strobe, rising edge loads
    logic oe;   // raw output enable, polarity per path
  } path_ctl_t;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = xcvr_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);

  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= 1'b0;
    end else begin
      sig_q <= sig;
    end
  end

  assign rise = sig & ~sig_q;

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int W      = xcvr_pkg::XCVR_W,
  parameter bit OE_LOW = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        src,
  input  xcvr_pkg::path_ctl_t ctl,
  output logic [W-1:0]        dat_o,
  output logic                drv_o
);

  logic         stb_rise;
  logic         load_en;
  logic [W-1:0] store_q;
  logic [W-1:0] store_d;
  logic [W-1:0] view;

  xcvr_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (ctl.stb),
    .rise (stb_rise)
  );

  // load while transparent (tracks the source) or on a strobe rise
  assign load_en = ctl.le | stb_rise;

  always_comb begin
    store_d = store_q;
    if (load_en) begin
      store_d = src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (load_en) begin
      store_q <= store_d;
    end
  end

  generate
    if (OE_LOW) begin : g_oe_low
      assign drv_o = ~ctl.oe;
    end else begin : g_oe_high
      assign drv_o = ctl.oe;
    end
  endgenerate

  assign view  = ctl.le ? src : store_q;
  assign dat_o = drv_o ? view : '0;

endmodule

// File: rtl/duplex_bus_xcvr.sv
module duplex_bus_xcvr #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic [W-1:0] a_out,
  output logic         a_drv
);

  localparam int NP = xcvr_pkg::NUM_PATHS;

  logic                rst_sync_n;
  logic [W-1:0]        src  [NP];
  logic [W-1:0]        dat  [NP];
  logic                drv  [NP];
  xcvr_pkg::path_ctl_t ctl  [NP];

  xcvr_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // path 0: A to B, enable active high; path 1: B to A, enable active low
  assign src[0] = a_in;
  assign src[1] = b_in;
  assign ctl[0] = '{le: ab_le, stb: ab_clk, oe: ab_oe};
  assign ctl[1] = '{le: ba_le, stb: ba_clk, oe: ba_oe_n};

  generate
    for (genvar g = 0; g < NP; g++) begin : g_path
      xcvr_path #(
        .W     (W),
        .OE_LOW(g == 1)
      ) u_path (
        .clk  (clk),
        .rst_n(rst_sync_n),
        .src  (src[g]),
        .ctl  (ctl[g]),
        .dat_o(dat[g]),
        .drv_o(drv[g])
      );
    end
  endgenerate

  assign b_out = dat[0];
  assign b_drv = drv[0];
  assign a_out = dat[1];
  assign a_drv = drv[1];

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input logic         clk,
  input logic         rst_ok,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_oe,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic [W-1:0] b_out,
  input logic         b_drv,
  input logic [W-1:0] a_out,
  input logic         a_drv
);

  AST_AB_THRU: assert property (@(posedge clk) disable iff (!rst_ok)
    (ab_oe && ab_le) |-> (b_out == a_in)); // R1

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (ab_oe && $past(ab_oe) && !ab_le && !$past(ab_le) &&
     !($past(ab_clk) && !$past(ab_clk, 2))) |-> (b_out == $past(b_out))); // R2

  AST_AB_CAPT: assert property (@(posedge clk) disable iff (!rst_ok)
    (ab_oe && !ab_le && !$past(ab_le) && $past(ab_clk) && !$past(ab_clk, 2))
    |-> (b_out == $past(a_in))); // R3

  AST_AB_OFF: assert property (@(posedge clk) disable iff (!rst_ok)
    !ab_oe |-> (!b_drv && b_out == '0)); // R4

  AST_BA_OFF: assert property (@(posedge clk) disable iff (!rst_ok)
    ba_oe_n |-> (!a_drv && a_out == '0)); // R5

  AST_BA_THRU: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ba_oe_n && ba_le) |-> (a_out == b_in)); // R5

endmodule

bind duplex_bus_xcvr xcvr_chk #(.W(W)) u_xcvr_chk (
  .clk    (clk),
  .rst_ok (rst_sync_n),
  .a_in   (a_in),
  .b_in   (b_in),
  .ab_oe  (ab_oe),
  .ab_le  (ab_le),
  .ab_clk (ab_clk),
  .ba_oe_n(ba_oe_n),
  .ba_le  (ba_le),
  .b_out  (b_out),
  .b_drv  (b_drv),
  .a_out  (a_out),
  .a_drv  (a_drv)
);

// File: tb/duplex_bus_xcvr_bench.sv
module duplex_bus_xcvr_bench;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         ab_oe, ab_le, ab_clk, ba_oe_n, ba_le, ba_clk;
  logic [W-1:0] b_out, a_out;
  logic         b_drv, a_drv;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  duplex_bus_xcvr #(.W(W)) u_duplex_bus_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  // one system clock edge, then settle at the falling edge
  task automatic go();
    @(posedge clk);
    @(negedge clk);
  endtask

  // d=0: A-to-B path, d=1: B-to-A path; en is the logical enable
  task automatic setp(input bit d, input bit le, input bit stb, input bit en, input logic [W-1:0] v);
    if (!d) begin
      ab_le = le; ab_clk = stb; ab_oe = en; a_in = v;
    end else begin
      ba_le = le; ba_clk = stb; ba_oe_n = !en; b_in = v;
    end
  endtask

  function automatic logic [W-1:0] rd(input bit d);
    return d ? a_out : b_out;
  endfunction

  function automatic logic [W-1:0] rdrv(input bit d);
    return {{(W-1){1'b0}}, d ? a_drv : b_drv};
  endfunction

  task automatic t_reset();
    check("R8 reset b_out", b_out, '0);
    check("R8 reset a_out", a_out, '0);
    check("R4 b_drv on", {{(W-1){1'b0}}, b_drv}, 1);
    check("R5 a_drv on", {{(W-1){1'b0}}, a_drv}, 1);
  endtask

  task automatic t_transparent(input bit d);
    setp(d, 1, 0, 1, 18'h2A5A5); #1;
    check(d ? "R5 thru 1" : "R1 thru 1", rd(d), 18'h2A5A5);
    setp(d, 1, 0, 1, 18'h15A5A); #1;
    check(d ? "R5 thru 2" : "R1 thru 2", rd(d), 18'h15A5A);
    setp(d, 1, 0, 1, 18'h3FFFF); #1;
    check(d ? "R5 thru 3" : "R1 thru 3", rd(d), 18'h3FFFF);
    go();
    check(d ? "R5 thru clk" : "R1 thru clk", rd(d), 18'h3FFFF);
  endtask

  task automatic t_latched(input bit d);
    logic [W-1:0] v = d ? 18'h01234 : 18'h2BCDE;
    setp(d, 1, 0, 1, v); go();
    setp(d, 0, 0, 1, ~v); go();
    check(d ? "R5 hold 1" : "R2 hold 1", rd(d), v);
    setp(d, 0, 0, 1, 18'h00F0F); go();
    check(d ? "R5 hold 2" : "R2 hold 2", rd(d), v);
  endtask

  task automatic t_clocked(input bit d);
    setp(d, 0, 0, 1, 18'h11111); go();
    setp(d, 0, 1, 1, 18'h11111); go();
    check(d ? "R5 capt 1" : "R3 capt 1", rd(d), 18'h11111);
    setp(d, 0, 1, 1, 18'h22222); go();
    check(d ? "R5 high steady" : "R2 high steady", rd(d), 18'h11111);
    setp(d, 0, 0, 1, 18'h33333); go();
    check(d ? "R5 fall no load" : "R3 fall no load", rd(d), 18'h11111);
    setp(d, 0, 1, 1, 18'h3C3C3); go();
    check(d ? "R5 capt 2" : "R3 capt 2", rd(d), 18'h3C3C3);
    setp(d, 0, 0, 1, 18'h3C3C3); go();
  endtask

  task automatic t_fall_hi(input bit d);
    setp(d, 1, 0, 1, 18'h0AAAA); go();
    setp(d, 1, 1, 1, 18'h0AAAA); go();
    setp(d, 0, 1, 1, 18'h15555); go();
    check("R6 le fall high", rd(d), 18'h0AAAA);
    setp(d, 0, 0, 1, 18'h15555); go();
    check("R6 strobe falls", rd(d), 18'h0AAAA);
    setp(d, 0, 0, 1, 18'h0F0F0); go();
    check("R6 strobe low", rd(d), 18'h0AAAA);
    setp(d, 0, 1, 1, 18'h0F0F0); go();
    check("R6 next rise", rd(d), 18'h0F0F0);
    setp(d, 0, 0, 1, 18'h0F0F0); go();
  endtask

  task automatic t_oe(input bit d);
    setp(d, 1, 0, 1, 18'h1ACE1); go();
    setp(d, 0, 0, 0, 18'h1ACE1); #1;
    check(d ? "R5 off data" : "R4 off data", rd(d), '0);
    check(d ? "R5 off drv" : "R4 off drv", rdrv(d), '0);
    go();
    setp(d, 0, 0, 1, 18'h1ACE1); #1;
    check("R7 reenable", rd(d), 18'h1ACE1);
    setp(d, 0, 0, 0, 18'h02468); go();
    setp(d, 0, 1, 0, 18'h02468); go();
    check(d ? "R5 off while load" : "R4 off while load", rd(d), '0);
    setp(d, 0, 0, 0, 18'h3FFFF); go();
    setp(d, 0, 0, 1, 18'h3FFFF); #1;
    check("R7 load while off", rd(d), 18'h02468);
    check("R7 drv back", rdrv(d), 1);
  endtask

  task automatic t_indep();
    setp(1, 1, 0, 1, 18'h13579); go();
    setp(1, 0, 0, 1, 18'h00000); go();
    setp(0, 1, 0, 1, 18'h3FFFF); go();
    setp(0, 0, 1, 1, 18'h12121); go();
    setp(0, 0, 0, 0, 18'h00007); go();
    check("R9 a_out kept", a_out, 18'h13579);
    setp(0, 0, 0, 1, 18'h0); setp(1, 1, 0, 1, 18'h2B2B2); go();
    setp(1, 0, 1, 1, 18'h30303); go();
    check("R9 b_out kept", b_out, 18'h12121);
  endtask

  task automatic t_async_reset();
    setp(0, 0, 0, 1, 18'h0); setp(1, 0, 0, 1, 18'h0);
    rst_n = 1'b0; #1;
    check("R8 async b_out", b_out, '0);
    check("R8 async a_out", a_out, '0);
    go(); rst_n = 1'b1;
    go(); go(); go();
    setp(0, 0, 1, 1, 18'h05050); go();
    check("R8 after release", b_out, 18'h05050);
  endtask

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    ab_oe = 1'b1; ab_le = 1'b0; ab_clk = 1'b0;
    ba_oe_n = 1'b0; ba_le = 1'b0; ba_clk = 1'b0;
    @(negedge clk); go(); rst_n = 1'b1;
    go(); go(); go();
    t_reset();
    for (int d = 0; d < 2; d++) begin
      t_transparent(d[0]);
      t_latched(d[0]);
      t_clocked(d[0]);
      t_fall_hi(d[0]);
      t_oe(d[0]);
    end
    t_indep();
    t_async_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(2_000_000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule